// File: doc/BRIEF.md
# Outstanding Abort Request Tracker

This block keeps a short, fully associative list of abort requests that are still waiting for their target command. Each entry names a submission queue and a 16-bit command identifier. The execution path presents every command to the tracker just before the command starts. The tracker compares that command with all live entries in parallel. On a hit, the command is flagged as aborted in the same cycle and one matching entry is released at the next clock edge.

A new abort request is taken into a free entry when the table has room. When all entries are occupied, the request is turned away with a limit-exceeded indication and is not queued. The decision uses the table contents at the start of the cycle. Dropping the controller enable, or asserting reset, empties the whole table.

Top module: `abort_tracker`

## Requirements
- R1: The table never holds more than SLOTS live entries (default 5), and `pend_cnt` reports the number of live entries.
- R2: A request (`req_valid`=1) that arrives while fewer than SLOTS entries are live raises `req_accept` in that cycle, and the live count rises by one after the clock edge.
- R3: A request that arrives while all SLOTS entries are live raises `req_limit` instead of `req_accept`, and the table is left unchanged.
- R4: A command matches an entry only when both its queue ID and its command identifier are equal to the entry's fields. A match on only one of the two fields gives `cmd_aborted`=0.
- R5: A presented command (`cmd_valid`=1) that matches a live entry raises `cmd_aborted` combinationally in the same cycle, and that entry is freed at the clock edge. With `cmd_valid`=0, no abort is reported and no entry is freed.
- R6: Reset, or `ctrl_en`=0, clears every entry by the following edge. While `ctrl_en`=0, `req_accept`, `req_limit` and `cmd_aborted` all stay 0.
- R7: When several live entries match one command, exactly one of them is freed: the lowest-numbered one.
- R8: A request and a command in the same cycle are each judged against the table as it stood before that edge. A slot freed by the command cannot take the request in that cycle, and a request written in that cycle cannot be matched by the command.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctrl_en | input | 1 | Controller enable; low clears the table |
| req_valid | input | 1 | Abort request present |
| req_qid | input | QID_W | Queue ID targeted by the request |
| req_cid | input | CID_W | Command identifier targeted by the request |
| req_accept | output | 1 | Request stored this cycle |
| req_limit | output | 1 | Request rejected: table full |
| cmd_valid | input | 1 | Command about to execute |
| cmd_qid | input | QID_W | Queue ID of that command |
| cmd_cid | input | CID_W | Identifier of that command |
| cmd_aborted | output | 1 | Command was requested to be aborted |
| pend_cnt | output | $clog2(SLOTS+1) | Number of live entries |

## Verification
The embedded assertions check the following on every cycle: the count bound, that accept and limit are exclusive, that the limit indication is raised only on a full table, that the count moves by exactly one on each lone accept or lone abort, and that a disable empties the table. Other behaviour can only be shown by the bench's scenarios. These are the two-field match rule, the single-entry release for duplicate requests, the same-cycle ordering between a request and a command, and the sweep of queue and identifier values.

// File: rtl/abort_tracker.sv
module abort_tracker #(
  parameter int SLOTS = 5,
  parameter int QID_W = 4,
  parameter int CID_W = 16,
  localparam int CNT_W = $clog2(SLOTS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctrl_en,
  input  logic             req_valid,
  input  logic [QID_W-1:0] req_qid,
  input  logic [CID_W-1:0] req_cid,
  output logic             req_accept,
  output logic             req_limit,
  input  logic             cmd_valid,
  input  logic [QID_W-1:0] cmd_qid,
  input  logic [CID_W-1:0] cmd_cid,
  output logic             cmd_aborted,
  output logic [CNT_W-1:0] pend_cnt
);

  logic [SLOTS-1:0] live;
  logic [QID_W-1:0] ent_qid [SLOTS];
  logic [CID_W-1:0] ent_cid [SLOTS];
  logic [SLOTS-1:0] hit, hit_pick, free_pick;

  for (genvar g = 0; g < SLOTS; g++) begin : g_cmp
    assign hit[g] = live[g] && cmd_valid && ent_qid[g] == cmd_qid && ent_cid[g] == cmd_cid;
  end

  always_comb begin
    logic hf, ff;
    hf = 1'b0;
    ff = 1'b0;
    hit_pick  = '0;
    free_pick = '0;
    for (int i = 0; i < SLOTS; i++) begin
      if (hit[i] && !hf) begin
        hit_pick[i] = 1'b1;
        hf = 1'b1;
      end
      if (!live[i] && !ff) begin
        free_pick[i] = 1'b1;
        ff = 1'b1;
      end
    end
  end

  assign req_accept  = ctrl_en && req_valid && !(&live);
  assign req_limit   = ctrl_en && req_valid && (&live);
  assign cmd_aborted = ctrl_en && (|hit);
  assign pend_cnt    = CNT_W'($countones(live));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live <= '0;
      for (int i = 0; i < SLOTS; i++) begin
        ent_qid[i] <= '0;
        ent_cid[i] <= '0;
      end
    end else if (!ctrl_en) begin
      live <= '0;
    end else begin
      for (int i = 0; i < SLOTS; i++) begin
        if (hit_pick[i]) live[i] <= 1'b0;
        if (req_accept && free_pick[i]) begin
          live[i]    <= 1'b1;
          ent_qid[i] <= req_qid;
          ent_cid[i] <= req_cid;
        end
      end
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    pend_cnt <= CNT_W'(SLOTS)); // R1
  AST_ACC_LIM_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_accept && req_limit)); // R3
  AST_LIMIT_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    req_limit |-> pend_cnt == CNT_W'(SLOTS)); // R3
  AST_ACCEPT_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_accept && !cmd_aborted) |=> (!ctrl_en || pend_cnt == $past(pend_cnt) + 1'b1)); // R2
  AST_ABORT_FREES: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_aborted && !req_accept) |=> (!ctrl_en || pend_cnt == $past(pend_cnt) - 1'b1)); // R5
  AST_DISABLE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_en |=> pend_cnt == '0); // R6
  AST_DISABLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_en |-> !(req_accept || req_limit || cmd_aborted)); // R6

endmodule

// File: tb/tb_abort_tracker.sv
module tb_abort_tracker;
  localparam int SLOTS = 5;
  logic clk = 0, rst_n = 0, ctrl_en = 0;
  logic req_valid = 0, cmd_valid = 0;
  logic [3:0] req_qid = 0, cmd_qid = 0;
  logic [15:0] req_cid = 0, cmd_cid = 0;
  logic req_accept, req_limit, cmd_aborted;
  logic [2:0] pend_cnt;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  abort_tracker dut (.clk(clk), .rst_n(rst_n), .ctrl_en(ctrl_en),
    .req_valid(req_valid), .req_qid(req_qid), .req_cid(req_cid),
    .req_accept(req_accept), .req_limit(req_limit),
    .cmd_valid(cmd_valid), .cmd_qid(cmd_qid), .cmd_cid(cmd_cid),
    .cmd_aborted(cmd_aborted), .pend_cnt(pend_cnt));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // one cycle: drive at negedge, check outputs mid-low phase, check count after edge
  task automatic step(input bit rv, input int rq, input int rc,
                      input bit cv, input int cq, input int cc,
                      input bit eacc, input bit elim, input bit eab,
                      input int ecnt, input string tag);
    @(negedge clk);
    req_valid = rv; req_qid = 4'(rq); req_cid = 16'(rc);
    cmd_valid = cv; cmd_qid = 4'(cq); cmd_cid = 16'(cc);
    #2;
    chk(req_accept == eacc, {tag, " accept"}, req_accept, eacc);
    chk(req_limit == elim, {tag, " limit"}, req_limit, elim);
    chk(cmd_aborted == eab, {tag, " aborted"}, cmd_aborted, eab);
    @(posedge clk); #1;
    chk(pend_cnt == 3'(ecnt), {tag, " count"}, pend_cnt, ecnt);
    req_valid = 0; cmd_valid = 0;
  endtask

  initial begin
    #1;
    chk(pend_cnt == 0, "R6 reset count", pend_cnt, 0);
    chk(!req_accept && !req_limit && !cmd_aborted, "R6 reset outputs", 0, 0);
    repeat (2) @(negedge clk);
    rst_n = 1; ctrl_en = 1;

    // R2 fill, R1 bound
    for (int k = 0; k < SLOTS; k++)
      step(1, k, 16'h1000 + k, 0, 0, 0, 1, 0, 0, k + 1, "R2 fill");
    // R3 overflow
    step(1, 9, 16'h2222, 0, 0, 0, 0, 1, 0, SLOTS, "R3 overflow");
    chk(pend_cnt <= SLOTS, "R1 bound", pend_cnt, SLOTS);
    // R4 partial matches
    step(0, 0, 0, 1, 2, 16'h1003, 0, 0, 0, SLOTS, "R4 cid mismatch");
    step(0, 0, 0, 1, 3, 16'h1002, 0, 0, 0, SLOTS, "R4 qid mismatch");
    step(0, 0, 0, 1, 9, 16'h2222, 0, 0, 0, SLOTS, "R3 rejected not stored");
    // R5 cmd_valid gate
    step(0, 0, 0, 0, 1, 16'h1001, 0, 0, 0, SLOTS, "R5 no valid");
    // R8 simultaneous with full table
    step(1, 7, 16'h7777, 1, 4, 16'h1004, 0, 1, 1, SLOTS - 1, "R8 full plus abort");
    step(1, 7, 16'h7777, 0, 0, 0, 1, 0, 0, SLOTS, "R8 retry");
    // R5 drain each
    for (int k = 0; k < 4; k++)
      step(0, 0, 0, 1, k, 16'h1000 + k, 0, 0, 1, SLOTS - 1 - k, "R5 drain");
    step(0, 0, 0, 1, 7, 16'h7777, 0, 0, 1, 0, "R5 drain last");
    step(0, 0, 0, 1, 0, 16'h1000, 0, 0, 0, 0, "R5 freed gone");
    // R7 duplicates
    step(1, 5, 16'hABCD, 0, 0, 0, 1, 0, 0, 1, "R7 dup a");
    step(1, 5, 16'hABCD, 0, 0, 0, 1, 0, 0, 2, "R7 dup b");
    step(0, 0, 0, 1, 5, 16'hABCD, 0, 0, 1, 1, "R7 one freed");
    step(0, 0, 0, 1, 5, 16'hABCD, 0, 0, 1, 0, "R7 second freed");
    // R8 request and same command together: new entry not visible
    step(1, 6, 16'h0606, 1, 6, 16'h0606, 1, 0, 0, 1, "R8 new not matched");
    step(0, 0, 0, 1, 6, 16'h0606, 0, 0, 1, 0, "R8 matched later");
    // R6 disable
    step(1, 1, 1, 0, 0, 0, 1, 0, 0, 1, "R6 prep a");
    step(1, 2, 2, 0, 0, 0, 1, 0, 0, 2, "R6 prep b");
    @(negedge clk); ctrl_en = 0;
    step(1, 3, 3, 1, 1, 1, 0, 0, 0, 0, "R6 disabled");
    @(negedge clk); ctrl_en = 1;
    step(0, 0, 0, 1, 2, 2, 0, 0, 0, 0, "R6 cleared");
    // R4 sweep over queue IDs
    for (int q = 0; q < 16; q++) begin
      step(1, q, q * 4099, 0, 0, 0, 1, 0, 0, 1, "R4 sweep insert");
      step(0, 0, 0, 1, q ^ 1, q * 4099, 0, 0, 0, 1, "R4 sweep wrong qid");
      step(0, 0, 0, 1, q, (q * 4099) ^ 16'h8000, 0, 0, 0, 1, "R4 sweep wrong cid");
      step(0, 0, 0, 1, q, q * 4099, 0, 0, 1, 0, "R4 sweep hit");
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=0 expected=1");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule